// File: doc/BRIEF.md
# Parallel IO pin-mux controller

This block controls one bank of general-purpose pins from a simple register bus. Every pin is either owned by the GPIO logic or handed to one of four peripheral functions (A, B, C, D). The block keeps per-pin state for ownership, output enable, output data, open-drain (multi-drive) mode, pull-up, pull-down, interrupt enable, Schmitt-trigger disable and a two-bit drive-strength code. From that state it drives the pad-ring controls.

Most per-pin settings are changed through write-1 "on" and "off" addresses. The on and off addresses read as zero, and a separate status address returns the current state. The two function-select words, the Schmitt word and the two drive-strength words are plain read/write registers. The bus is single-cycle: a write takes effect at the clock edge on which `bus_we` is high. Read data is combinational from `bus_addr`.

When a pin is owned by a peripheral, its pad enable and value come from that peripheral's input vectors. The pin's select bits choose the peripheral. The block has no state machine. Its only sequential elements are the per-pin registers and the pad-input capture stage.

Top module: `pmx_bank_ctrl`

## Requirements
- R1: After reset every pin is GPIO-owned (ownership status all ones). Output enable, output data, multi-drive, pull-up, pull-down, interrupt enable, both select words, the Schmitt word and both drive words are all zero.
- R2: Per-pin settings are indexed as ownership=0, output enable=1, output data=2, multi-drive=3, pull-up=4, pull-down=5, interrupt enable=6. Setting k has its "on" address at 3k, its "off" address at 3k+1 and its status address at 3k+2. Writing "on" sets the bits that are 1 in the written word, and writing "off" clears them. Bits written as 0 keep their value. The new state reads back from the status address after the write edge.
- R3: Every "on" and "off" address reads as zero.
- R4: Select word 1 (address 21), select word 2 (address 22), the Schmitt-disable word (address 23), drive word low (address 24) and drive word high (address 25) are plain read/write registers and read back the value last written.
- R5: `pad_fsel[2p+1:2p]` equals {select2[p], select1[p]}, so function A=0, B=1, C=2 and D=3. A peripheral-owned pin takes its enable and value from bit f*32+p of `periph_oe` and `periph_out`, where f is that code.
- R6: A GPIO-owned pin takes its pad value from its output-data bit and its drive enable from its output-enable bit.
- R7: When a pin's multi-drive bit is set and its pad value is 1, `pad_oe` for that pin is 0. Otherwise `pad_oe` equals the drive enable.
- R8: `pad_drv[2p+1:2p]` is bits [2p+1:2p] of drive word low for pins 0 to 15, and bits [2(p-16)+1:2(p-16)] of drive word high for pins 16 to 31.
- R9: Address 26 returns the `pad_in` levels captured at the previous clock edge. Writes to it have no effect.
- R10: `pad_pu`, `pad_pd`, `pad_schmitt_off` and `irq_en` follow the pull-up, pull-down, Schmitt-disable and interrupt-enable state bit for bit.
- R11: Addresses 27 to 63 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data / pin mask |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 32 | Pad input levels |
| periph_oe | input | 128 | Peripheral drive enables, function f at bits f*32+p |
| periph_out | input | 128 | Peripheral output values, same layout |
| pad_oe | output | 32 | Pad output enable |
| pad_out | output | 32 | Pad output value |
| pad_pu | output | 32 | Pull-up enable |
| pad_pd | output | 32 | Pull-down enable |
| pad_schmitt_off | output | 32 | Schmitt trigger disable |
| pad_drv | output | 64 | Two-bit drive-strength code per pin |
| pad_fsel | output | 64 | Two-bit peripheral function code per pin |
| irq_en | output | 32 | Interrupt enable per pin |

## Verification
A wrong state bit in this block shows at the pads and in the status words on the cycle after the write that caused it. Nothing is hidden behind a pipeline. A bad select or ownership bit routes the wrong vector to `pad_oe` and `pad_out` at once. A bad drive-word mapping shows as a shifted pair in `pad_drv`. The bench sweeps every setting with many masks and sweeps the select and ownership words against varied peripheral vectors. It also walks the whole unmapped address range. After each operation it compares the status words and every pad output with a bench model.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    localparam int NSET        = 7;
    localparam int SET_GPIO    = 0;
    localparam int SET_OE      = 1;
    localparam int SET_DAT     = 2;
    localparam int SET_MD      = 3;
    localparam int SET_PU      = 4;
    localparam int SET_PD      = 5;
    localparam int SET_IM      = 6;
    localparam int ADDR_SEL1   = 3 * NSET;
    localparam int ADDR_SEL2   = ADDR_SEL1 + 1;
    localparam int ADDR_SCHM   = ADDR_SEL1 + 2;
    localparam int ADDR_DRV_LO = ADDR_SEL1 + 3;
    localparam int ADDR_DRV_HI = ADDR_SEL1 + 4;
    localparam int ADDR_PADIN  = ADDR_SEL1 + 5;

    typedef enum logic [1:0] {
        FN_A = 2'd0,
        FN_B = 2'd1,
        FN_C = 2'd2,
        FN_D = 2'd3
    } pmx_fn_e;
endpackage

// File: rtl/pmx_setclr_reg.sv
module pmx_setclr_reg #(
    parameter int             W       = 32,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (set_stb) begin
            q <= q | wmask;
        end else if (clr_stb) begin
            q <= q & ~wmask;
        end
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((q & $past(wmask)) == $past(wmask)));
    // R2
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb) |=> ((q & $past(wmask)) == '0));
    // R2
    hold_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(q));
endmodule

// File: rtl/pmx_pad_route.sv
module pmx_pad_route #(
    parameter int NPINS = 32,
    parameter int NFN   = 4
) (
    input  logic [NPINS-1:0]     own_gpio,
    input  logic [NPINS-1:0]     gpio_oe,
    input  logic [NPINS-1:0]     gpio_dat,
    input  logic [NPINS-1:0]     multi_drv,
    input  logic [NPINS-1:0]     sel1,
    input  logic [NPINS-1:0]     sel2,
    input  logic [NFN*NPINS-1:0] periph_oe,
    input  logic [NFN*NPINS-1:0] periph_out,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS-1:0]     pad_out,
    output logic [2*NPINS-1:0]   pad_fsel
);
    import pmx_pkg::*;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pmx_fn_e        fn;
        logic [NFN-1:0] oe_vec;
        logic [NFN-1:0] val_vec;
        logic           drv_en;
        logic           val;

        assign fn = pmx_fn_e'({sel2[p], sel1[p]});
        for (genvar f = 0; f < NFN; f++) begin : g_fn
            assign oe_vec[f]  = periph_oe[f*NPINS+p];
            assign val_vec[f] = periph_out[f*NPINS+p];
        end
        assign val    = own_gpio[p] ? gpio_dat[p] : val_vec[fn];
        assign drv_en = own_gpio[p] ? gpio_oe[p]  : oe_vec[fn];
        assign pad_out[p]         = val;
        assign pad_oe[p]          = drv_en & ~(multi_drv[p] & val);
        assign pad_fsel[2*p +: 2] = fn;
    end
endmodule

// File: rtl/pmx_bank_ctrl.sv
module pmx_bank_ctrl #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NPINS-1:0]   bus_wdata,
    output logic [NPINS-1:0]   bus_rdata,
    input  logic [NPINS-1:0]   pad_in,
    input  logic [4*NPINS-1:0] periph_oe,
    input  logic [4*NPINS-1:0] periph_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_pu,
    output logic [NPINS-1:0]   pad_pd,
    output logic [NPINS-1:0]   pad_schmitt_off,
    output logic [2*NPINS-1:0] pad_drv,
    output logic [2*NPINS-1:0] pad_fsel,
    output logic [NPINS-1:0]   irq_en
);
    import pmx_pkg::*;

    localparam int HALF = NPINS / 2;

    logic [NSET-1:0][NPINS-1:0] stat;
    logic [NSET-1:0]            set_stb;
    logic [NSET-1:0]            clr_stb;
    logic [NPINS-1:0]           sel1_q, sel2_q, schm_q, drv_lo_q, drv_hi_q, padin_q;
    logic                       wo_hit;

    for (genvar i = 0; i < NSET; i++) begin : g_set
        localparam logic [NPINS-1:0] RV = (i == SET_GPIO) ? '1 : '0;
        assign set_stb[i] = bus_we && (bus_addr == ADDR_W'(3*i));
        assign clr_stb[i] = bus_we && (bus_addr == ADDR_W'(3*i+1));
        pmx_setclr_reg #(.W(NPINS), .RST_VAL(RV)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_stb[i]),
            .clr_stb (clr_stb[i]),
            .wmask   (bus_wdata),
            .q       (stat[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel1_q   <= '0;
            sel2_q   <= '0;
            schm_q   <= '0;
            drv_lo_q <= '0;
            drv_hi_q <= '0;
            padin_q  <= '0;
        end else begin
            padin_q <= pad_in;
            if (bus_we) begin
                if (bus_addr == ADDR_W'(ADDR_SEL1))   sel1_q   <= bus_wdata;
                if (bus_addr == ADDR_W'(ADDR_SEL2))   sel2_q   <= bus_wdata;
                if (bus_addr == ADDR_W'(ADDR_SCHM))   schm_q   <= bus_wdata;
                if (bus_addr == ADDR_W'(ADDR_DRV_LO)) drv_lo_q <= bus_wdata;
                if (bus_addr == ADDR_W'(ADDR_DRV_HI)) drv_hi_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        wo_hit    = 1'b0;
        for (int i = 0; i < NSET; i++) begin
            if (bus_addr == ADDR_W'(3*i+2)) bus_rdata = stat[i];
            if (bus_addr == ADDR_W'(3*i) || bus_addr == ADDR_W'(3*i+1)) wo_hit = 1'b1;
        end
        if (bus_addr == ADDR_W'(ADDR_SEL1))   bus_rdata = sel1_q;
        if (bus_addr == ADDR_W'(ADDR_SEL2))   bus_rdata = sel2_q;
        if (bus_addr == ADDR_W'(ADDR_SCHM))   bus_rdata = schm_q;
        if (bus_addr == ADDR_W'(ADDR_DRV_LO)) bus_rdata = drv_lo_q;
        if (bus_addr == ADDR_W'(ADDR_DRV_HI)) bus_rdata = drv_hi_q;
        if (bus_addr == ADDR_W'(ADDR_PADIN))  bus_rdata = padin_q;
    end

    pmx_pad_route #(.NPINS(NPINS), .NFN(4)) u_route (
        .own_gpio   (stat[SET_GPIO]),
        .gpio_oe    (stat[SET_OE]),
        .gpio_dat   (stat[SET_DAT]),
        .multi_drv  (stat[SET_MD]),
        .sel1       (sel1_q),
        .sel2       (sel2_q),
        .periph_oe  (periph_oe),
        .periph_out (periph_out),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_fsel   (pad_fsel)
    );

    assign pad_pu          = stat[SET_PU];
    assign pad_pd          = stat[SET_PD];
    assign irq_en          = stat[SET_IM];
    assign pad_schmitt_off = schm_q;
    assign pad_drv         = {drv_hi_q[2*HALF-1:0], drv_lo_q[2*HALF-1:0]};

    // R3
    wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wo_hit |-> (bus_rdata == '0));
    // R7
    open_drain_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & stat[SET_MD] & pad_oe) == '0));
    // R11
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr > ADDR_W'(ADDR_PADIN)) |=> ($stable(sel1_q) && $stable(sel2_q) && $stable(stat)));
endmodule

// File: tb/tb_pmx_bank_ctrl.sv
module tb_pmx_bank_ctrl;
    localparam int N = 32;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         bus_we = 0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [31:0]  pad_in = '0;
    logic [127:0] periph_oe = '0;
    logic [127:0] periph_out = '0;
    logic [31:0]  pad_oe, pad_out, pad_pu, pad_pd, pad_schmitt_off, irq_en;
    logic [63:0]  pad_drv, pad_fsel;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] m [7];
    logic [31:0] m_sel1, m_sel2, m_schm, m_lo, m_hi;

    always #5 clk = ~clk;

    pmx_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .periph_oe(periph_oe), .periph_out(periph_out), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_schmitt_off(pad_schmitt_off), .pad_drv(pad_drv),
        .pad_fsel(pad_fsel), .irq_en(irq_en)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'(a);
        #1 d = bus_rdata;
    endtask

    task automatic check_pads(string req);
        logic [31:0] eo, ev;
        logic [63:0] ef, ed;
        for (int p = 0; p < N; p++) begin
            int f;
            logic en, v;
            f = 2*int'(m_sel2[p]) + int'(m_sel1[p]);
            v  = m[0][p] ? m[2][p] : periph_out[f*N+p];
            en = m[0][p] ? m[1][p] : periph_oe[f*N+p];
            ev[p] = v;
            eo[p] = en & !(m[3][p] & v);
            ef[2*p +: 2] = 2'(f);
            ed[2*p +: 2] = (p < 16) ? m_lo[2*p +: 2] : m_hi[2*(p-16) +: 2];
        end
        #1;
        chk({req, " R6 pad_out"}, 64'(pad_out), 64'(ev));
        chk({req, " R7 pad_oe"}, 64'(pad_oe), 64'(eo));
        chk({req, " R5 pad_fsel"}, pad_fsel, ef);
        chk({req, " R8 pad_drv"}, pad_drv, ed);
        chk({req, " R10 pad_pu"}, 64'(pad_pu), 64'(m[4]));
        chk({req, " R10 pad_pd"}, 64'(pad_pd), 64'(m[5]));
        chk({req, " R10 irq_en"}, 64'(irq_en), 64'(m[6]));
        chk({req, " R10 schmitt"}, 64'(pad_schmitt_off), 64'(m_schm));
    endtask

    task automatic check_all(string req);
        logic [31:0] d;
        for (int k = 0; k < 7; k++) begin
            rd(3*k+2, d);
            chk({req, " R2 status"}, 64'(d), 64'(m[k]));
        end
        rd(21, d); chk({req, " R4 sel1"}, 64'(d), 64'(m_sel1));
        rd(22, d); chk({req, " R4 sel2"}, 64'(d), 64'(m_sel2));
        rd(23, d); chk({req, " R4 schmitt"}, 64'(d), 64'(m_schm));
        rd(24, d); chk({req, " R4 drv_lo"}, 64'(d), 64'(m_lo));
        rd(25, d); chk({req, " R4 drv_hi"}, 64'(d), 64'(m_hi));
        check_pads(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, w;
        m[0] = '1;
        for (int k = 1; k < 7; k++) m[k] = '0;
        m_sel1 = '0; m_sel2 = '0; m_schm = '0; m_lo = '0; m_hi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check_all("R1");

        // R2, R3 set/clear sweep over every setting
        for (int k = 0; k < 7; k++) begin
            for (int t = 0; t < 4; t++) begin
                w = $urandom;
                wr(3*k, w); m[k] = m[k] | w;
                rd(3*k+2, d); chk("R2 on", 64'(d), 64'(m[k]));
                check_pads("R2 on");
                w = $urandom;
                wr(3*k+1, w); m[k] = m[k] & ~w;
                rd(3*k+2, d); chk("R2 off", 64'(d), 64'(m[k]));
                check_pads("R2 off");
                rd(3*k, d);   chk("R3 on reads zero", 64'(d), 64'(0));
                rd(3*k+1, d); chk("R3 off reads zero", 64'(d), 64'(0));
            end
        end

        // R4, R8 plain registers
        for (int a = 21; a <= 25; a++) begin
            for (int t = 0; t < 4; t++) begin
                w = $urandom;
                wr(a, w);
                case (a)
                    21: m_sel1 = w;
                    22: m_sel2 = w;
                    23: m_schm = w;
                    24: m_lo = w;
                    default: m_hi = w;
                endcase
                rd(a, d); chk("R4 readback", 64'(d), 64'(w));
                check_pads("R4/R8");
            end
        end

        // R5, R6, R7 routing sweep
        for (int t = 0; t < 24; t++) begin
            w = $urandom; wr(0, w); m[0] = m[0] | w;
            w = $urandom; wr(1, w); m[0] = m[0] & ~w;
            w = $urandom; wr(21, w); m_sel1 = w;
            w = $urandom; wr(22, w); m_sel2 = w;
            w = $urandom; wr(9, w);  m[3] = m[3] | w;
            w = $urandom; wr(10, w); m[3] = m[3] & ~w;
            @(negedge clk);
            periph_oe  = {$urandom, $urandom, $urandom, $urandom};
            periph_out = {$urandom, $urandom, $urandom, $urandom};
            check_pads("R5 route");
        end
        // R5 all-peripheral, each uniform function
        wr(1, '1); m[0] = '0;
        for (int f = 0; f < 4; f++) begin
            wr(21, (f & 1) ? '1 : '0); m_sel1 = (f & 1) ? '1 : '0;
            wr(22, (f & 2) ? '1 : '0); m_sel2 = (f & 2) ? '1 : '0;
            check_pads("R5 uniform fn");
        end

        // R9 pad input capture
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            w = $urandom; pad_in = w;
            rd(26, d); chk("R9 pad_in", 64'(d), 64'(w));
        end
        wr(26, 32'h0); rd(26, d); chk("R9 write ignored", 64'(d), 64'(w));

        // R11 unmapped addresses
        for (int a = 27; a < 64; a++) begin
            wr(a, '1);
            rd(a, d); chk("R11 unmapped read", 64'(d), 64'(0));
        end
        check_all("R11");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule